// File: doc/BRIEF.md
# Dual-Channel Tone and Voltage-Select Controller

This block produces the digital control signals for two independent antenna supply outputs. A single divider turns the converter switching clock into a square-wave tone at one tenth of its rate. Both halves of the tone are equally long. Each channel then decides whether that tone reaches its output. Either a register force bit keeps the tone on continuously, or an external modulation pin switches it on and off for burst signalling.

Each channel also produces a two-bit code that picks the supply level. The code comes from the channel's voltage-select bit and its cable-loss compensation bit. An external high-level pin can override both bits. When a channel's enable is low, its tone is silenced at once.

The two external pins of each channel are asynchronous. They pass through two flip-flops before they are used. Modulation decisions take effect only at tone period boundaries, so the output never carries a shortened pulse. The analog wave shaping, the regulators and the converters are outside this block.

Top module: `dual_tone_vsel_ctl`

## Requirements
- R1: The tone period is exactly DIV clock cycles (default 10). The internal phase counter runs from 0 to DIV-1 and then wraps to 0.
- R2: The tone duty cycle is 50 percent. A gated tone is high while the phase is below DIV/2 and low for the remaining DIV/2 cycles.
- R3: With the channel's force bit at 1 and the channel enabled, the tone runs continuously from the next period boundary, and the modulation pin has no effect on it.
- R4: With the force bit at 0, the modulation pin, seen after two synchronizing flops, decides whether the tone is on (pin high = on). That decision is sampled only in the last phase cycle (phase DIV-1), so the tone always starts and stops on whole periods.
- R5: With the 18V pin low, the voltage code is {vsel, llc}: 2'b00 = 13V, 2'b01 = 14V, 2'b10 = 18V, 2'b11 = 19V. Channel c's code sits at bits [2c+1:2c] of `vcode_o`.
- R6: When the synchronized 18V pin of a channel is high, that channel's code is 2'b10 (18V), whatever its vsel and llc bits. The pin acts on the code two clocks after it is sampled.
- R7: When a channel's enable is 0, its tone and tone-active outputs are low in the same cycle. Its gating decision is cleared, so after re-enabling the tone waits for the next period boundary.
- R8: The tone-active flag is high exactly while the channel is enabled and its current period is gated on. The tone is never high while the flag is low.
- R9: The two channels are independent. The inputs of one channel never change the outputs of the other, and both may run tones at the same time.
- R10: While reset is low, and in the first cycle after it, both tones and both active flags are low. The phase counter and the synchronizers start from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Converter switching clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| chan_en_i | input | N_CH | Per-channel enable |
| tone_force_i | input | N_CH | Per-channel continuous-tone force bit |
| vsel_i | input | N_CH | Per-channel high-level select bit |
| llc_i | input | N_CH | Per-channel cable-loss compensation bit |
| mod_pin_i | input | N_CH | Per-channel asynchronous modulation pin |
| sel18_pin_i | input | N_CH | Per-channel asynchronous 18V override pin |
| tone_o | output | N_CH | Per-channel gated tone waveform |
| tone_active_o | output | N_CH | Per-channel tone-active flag |
| vcode_o | output | 2*N_CH | Per-channel voltage codes, channel c at [2c+1:2c] |

## Verification
The assertions assume three things. DIV is even. Reset is held low for at least one clock before the first checked edge. The register bits (enable, force, vsel, llc) are synchronous to the clock, because they drive outputs without any flops in between. The stimulus changes every input a short time after the rising edge, so register bits never move near a sampling edge. The asynchronous pins are treated the same way; this keeps the two-flop latency deterministic and gives a bench-side model with a fixed delay. Directed sequences then cover each voltage combination, override, burst length and enable drop. A long pseudo-random run then mixes all inputs freely within the same timing rule.

// File: rtl/lnb_ctl_pkg.sv
// Package: shared types for the dual tone / voltage-select controller.
// Assumes nothing beyond a two-bit code per channel.
package lnb_ctl_pkg;

    // Voltage code per channel: upper bit = high level, lower bit = +1V step.
    typedef enum logic [1:0] {
        VC_13V = 2'b00,
        VC_14V = 2'b01,
        VC_18V = 2'b10,
        VC_19V = 2'b11
    } vcode_e;

endpackage

// File: rtl/tone_phase_gen.sv
// Module: tone_phase_gen
// Counts the switching clock modulo DIV and reports the tone phase.
// phase_hi_o is high for the first DIV/2 counts, and wrap_o marks the
// last count of each period.
// Assumes: DIV is even and at least 2.
module tone_phase_gen #(
    parameter int unsigned DIV = 10
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    output logic [$clog2(DIV)-1:0] cnt_o,
    output logic                   phase_hi_o,
    output logic                   wrap_o
);
    localparam int unsigned CW = $clog2(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);
    localparam logic [CW-1:0] HALF = CW'(DIV / 2);
    localparam logic [CW-1:0] ONE  = CW'(1);

    logic [CW-1:0] cnt_q;

    // Purpose: modulo-DIV phase counter.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)            cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + ONE;
    end

    assign cnt_o      = cnt_q;
    assign phase_hi_o = (cnt_q < HALF);
    assign wrap_o     = (cnt_q == LAST);
endmodule

// File: rtl/pin_sync.sv
// Module: pin_sync
// Multi-stage flip-flop synchronizer for a bus of independent asynchronous
// pins. Each bit is synchronized on its own, with no bus coherency.
// Assumes: STAGES >= 2.
module pin_sync #(
    parameter int unsigned W      = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] dout_o
);
    logic [W-1:0] stage_q [STAGES];

    // Purpose: shift the pin values through the synchronizer chain.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= din_i;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign dout_o = stage_q[STAGES-1];
endmodule

// File: rtl/chan_ctl.sv
// Module: chan_ctl
// One channel. It latches the tone gating decision at each period boundary,
// masks the shared tone with that decision and with the channel enable,
// and resolves the voltage code.
// Assumes: mod_s_i and sel_s_i are already synchronized to clk_i.
module chan_ctl
    import lnb_ctl_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       en_i,
    input  logic       force_i,
    input  logic       vsel_i,
    input  logic       llc_i,
    input  logic       mod_s_i,
    input  logic       sel_s_i,
    input  logic       phase_hi_i,
    input  logic       wrap_i,
    output logic       tone_o,
    output logic       active_o,
    output logic [1:0] code_o
);
    logic   gate_q;
    vcode_e code_d;

    // Purpose: take the gating decision only at period boundaries; clear it when disabled.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)     gate_q <= 1'b0;
        else if (!en_i)  gate_q <= 1'b0;
        else if (wrap_i) gate_q <= force_i | mod_s_i;
    end

    // Purpose: resolve the voltage code, with the external override winning.
    always_comb begin
        if (sel_s_i) code_d = VC_18V;
        else         code_d = vcode_e'({vsel_i, llc_i});
    end

    assign tone_o   = en_i & gate_q & phase_hi_i;
    assign active_o = en_i & gate_q;
    assign code_o   = code_d;
endmodule

// File: rtl/dual_tone_vsel_ctl.sv
// Module: dual_tone_vsel_ctl (top)
// A shared divide-by-DIV tone generator feeding N_CH independent channel
// controllers. The modulation and 18V override pins are synchronized here.
// Assumes: register-side inputs are synchronous to clk_i; DIV even.
module dual_tone_vsel_ctl #(
    parameter int unsigned N_CH        = 2,
    parameter int unsigned DIV         = 10,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [N_CH-1:0]   chan_en_i,
    input  logic [N_CH-1:0]   tone_force_i,
    input  logic [N_CH-1:0]   vsel_i,
    input  logic [N_CH-1:0]   llc_i,
    input  logic [N_CH-1:0]   mod_pin_i,
    input  logic [N_CH-1:0]   sel18_pin_i,
    output logic [N_CH-1:0]   tone_o,
    output logic [N_CH-1:0]   tone_active_o,
    output logic [2*N_CH-1:0] vcode_o
);
    localparam int unsigned CW = $clog2(DIV);

    logic [CW-1:0]   phase_cnt;
    logic            phase_hi;
    logic            phase_wrap;
    logic [N_CH-1:0] mod_sync;
    logic [N_CH-1:0] sel_sync;

    tone_phase_gen #(.DIV(DIV)) i_phase (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .cnt_o      (phase_cnt),
        .phase_hi_o (phase_hi),
        .wrap_o     (phase_wrap)
    );

    pin_sync #(.W(2*N_CH), .STAGES(SYNC_STAGES)) i_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .din_i  ({sel18_pin_i, mod_pin_i}),
        .dout_o ({sel_sync, mod_sync})
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_chan
        chan_ctl i_chan (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .en_i       (chan_en_i[c]),
            .force_i    (tone_force_i[c]),
            .vsel_i     (vsel_i[c]),
            .llc_i      (llc_i[c]),
            .mod_s_i    (mod_sync[c]),
            .sel_s_i    (sel_sync[c]),
            .phase_hi_i (phase_hi),
            .wrap_i     (phase_wrap),
            .tone_o     (tone_o[c]),
            .active_o   (tone_active_o[c]),
            .code_o     (vcode_o[2*c +: 2])
        );
    end
endmodule

// File: rtl/dual_tone_vsel_ctl_chk.sv
// Module: dual_tone_vsel_ctl_chk
// Property checker bound to the top. It watches the ports, the phase
// counter and the synchronized override pins.
// Assumes: reset is low at time zero.
module dual_tone_vsel_ctl_chk #(
    parameter int unsigned N_CH = 2,
    parameter int unsigned DIV  = 10
) (
    input logic                   clk_i,
    input logic                   rst_ni,
    input logic [N_CH-1:0]        chan_en_i,
    input logic [N_CH-1:0]        tone_o,
    input logic [N_CH-1:0]        tone_active_o,
    input logic [2*N_CH-1:0]      vcode_o,
    input logic [$clog2(DIV)-1:0] phase_cnt,
    input logic [N_CH-1:0]        sel_sync
);
    localparam int unsigned CW = $clog2(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);
    localparam logic [CW-1:0] HALF = CW'(DIV / 2);
    localparam logic [CW-1:0] ONE  = CW'(1);

    assert_phase_wrap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase_cnt == LAST) |=> (phase_cnt == '0));

    assert_phase_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase_cnt != LAST) |=> (phase_cnt == $past(phase_cnt) + ONE));

    for (genvar c = 0; c < N_CH; c++) begin : g_chk
        assert_tone_first_half_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            tone_o[c] |-> (phase_cnt < HALF));

        assert_gate_on_boundary_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (chan_en_i[c] && $past(chan_en_i[c]) && ($past(phase_cnt) != LAST))
            |-> (tone_active_o[c] == $past(tone_active_o[c])));

        assert_override_18v_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            sel_sync[c] |-> (vcode_o[2*c +: 2] == 2'b10));

        assert_disabled_silent_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !chan_en_i[c] |-> (!tone_o[c] && !tone_active_o[c]));

        assert_tone_needs_active_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            tone_o[c] |-> tone_active_o[c]);
    end
endmodule

bind dual_tone_vsel_ctl dual_tone_vsel_ctl_chk #(.N_CH(N_CH), .DIV(DIV)) i_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .chan_en_i     (chan_en_i),
    .tone_o        (tone_o),
    .tone_active_o (tone_active_o),
    .vcode_o       (vcode_o),
    .phase_cnt     (phase_cnt),
    .sel_sync      (sel_sync)
);

// File: tb/test_dual_tone_vsel_ctl.sv
module test_dual_tone_vsel_ctl;
    localparam int N   = 2;
    localparam int DIV = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] en = '0, frc = '0, vsel = '0, llc = '0, mod = '0, sel = '0;
    logic [N-1:0] tone, act;
    logic [2*N-1:0] vcode;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;
    bit done    = 1'b0;

    // Reference model state
    int           ref_phase = 0;
    bit [N-1:0]   ref_gate  = '0;
    logic [N-1:0] modq[$];
    logic [N-1:0] selq[$];

    always #10 clk = ~clk;

    dual_tone_vsel_ctl #(.N_CH(N), .DIV(DIV)) i_dual_tone_vsel_ctl (
        .clk_i(clk), .rst_ni(rst_n), .chan_en_i(en), .tone_force_i(frc),
        .vsel_i(vsel), .llc_i(llc), .mod_pin_i(mod), .sel18_pin_i(sel),
        .tone_o(tone), .tone_active_o(act), .vcode_o(vcode)
    );

    task automatic chk(input bit ok, input string tag, input int actual, input int expected);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at t=%0t", tag, actual, expected, $time);
        end
    endtask

    // Behavioural reference: advance model state on every rising edge.
    initial begin
        modq = '{'0, '0};
        selq = '{'0, '0};
    end
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            ref_phase = 0;
            ref_gate  = '0;
            modq = '{'0, '0};
            selq = '{'0, '0};
        end else begin
            for (int c = 0; c < N; c++) begin
                if (!en[c]) ref_gate[c] = 1'b0;
                else if (ref_phase == DIV - 1) ref_gate[c] = frc[c] | modq[0][c];
            end
            ref_phase = (ref_phase + 1) % DIV;
            modq.push_back(mod); void'(modq.pop_front());
            selq.push_back(sel); void'(selq.pop_front());
        end
    end

    // Compare every channel on every falling edge.
    always @(negedge clk) begin
        if (!done) begin
            for (int c = 0; c < N; c++) begin
                bit exp_t, exp_a;
                int exp_code;
                string ttag, ctag;
                exp_a = en[c] && ref_gate[c];
                exp_t = exp_a && (ref_phase < DIV / 2);
                exp_code = selq[0][c] ? 2 : int'({vsel[c], llc[c]});
                ttag = !en[c] ? "R7 tone" : (frc[c] ? "R3 tone" : "R4 tone");
                ctag = selq[0][c] ? "R6 code" : "R5 code";
                chk(tone[c] == exp_t, ttag, tone[c], exp_t);
                chk(act[c] == exp_a, "R8 active", act[c], exp_a);
                chk(int'(vcode[2*c +: 2]) == exp_code, ctag, vcode[2*c +: 2], exp_code);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        bit samp [40];
        int rise0, rise1, hi_run;

        // R10: reset state
        step(4);
        @(negedge clk); #1;
        chk(tone == '0, "R10 tone in reset", tone, 0);
        chk(act == '0, "R10 active in reset", act, 0);
        step(1);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(tone == '0 && act == '0, "R10 first cycle after reset", {tone, act}, 0);

        // R3 with R1/R2 measurement: force channel 0, toggle its pin
        step(1);
        en = 2'b01; frc = 2'b01;
        step(12);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk); #1;
            samp[i] = tone[0];
            mod[0] = ~mod[0];
        end
        rise0 = -1; rise1 = -1; hi_run = 0;
        for (int i = 1; i < 40; i++) begin
            if (samp[i] && !samp[i-1]) begin
                if (rise0 < 0) rise0 = i;
                else if (rise1 < 0) rise1 = i;
            end
        end
        for (int i = rise0; i < 40 && i >= 0 && samp[i]; i++) hi_run++;
        chk(rise1 - rise0 == DIV, "R1 tone period", rise1 - rise0, DIV);
        chk(hi_run == DIV / 2, "R2 high half-period", hi_run, DIV / 2);
        chk(tone[1] == 1'b0 && act[1] == 1'b0, "R9 idle channel 1", {tone[1], act[1]}, 0);

        // R4: pin-gated bursts on channel 1 while channel 0 stays forced (R9)
        step(1);
        mod = '0; en = 2'b11;
        for (int b = 0; b < 6; b++) begin
            mod[1] = 1'b1; step(3 + 7 * b);
            mod[1] = 1'b0; step(5 + 4 * b);
        end
        @(negedge clk); #1;
        chk(act[0] == 1'b1, "R9 channel 0 unaffected", act[0], 1);

        // R5: all codes on both channels, override low
        for (int v = 0; v < 4; v++) begin
            step(1);
            vsel = {v[0], v[1]}; llc = {v[1], v[0]};
            @(negedge clk); #1;
            chk(int'(vcode[1:0]) == v, "R5 code ch0", vcode[1:0], v);
        end

        // R6: override on each combination
        for (int v = 0; v < 4; v++) begin
            step(1);
            vsel = {v[1], v[0]}; llc = {v[0], v[1]}; sel = 2'b01;
            step(2);
            @(negedge clk); #1;
            chk(vcode[1:0] == 2'b10, "R6 override ch0", vcode[1:0], 2);
        end
        step(1);
        sel = '0;

        // R7: drop the enable mid-tone, then bring it back
        frc = 2'b11;
        step(23);
        en = 2'b10;
        @(negedge clk); #1;
        chk(tone[0] == 1'b0 && act[0] == 1'b0, "R7 disable immediate", {tone[0], act[0]}, 0);
        step(7);
        en = 2'b11;
        step(20);

        // Mixed pseudo-random run
        for (int i = 0; i < 4000; i++) begin
            step(1);
            if ($urandom_range(0, 7) == 0) en   = N'($urandom);
            if ($urandom_range(0, 15) == 0) frc = N'($urandom);
            if ($urandom_range(0, 3) == 0) mod  = N'($urandom);
            if ($urandom_range(0, 9) == 0) sel  = N'($urandom);
            vsel = N'($urandom); llc = N'($urandom);
        end
        step(2);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule